// File: doc/BRIEF.md
# Transceiver Power Mode Controller

This block is the control state machine that decides the operating and low-power modes of a fault-tolerant bus transceiver. Two active-high control pins (a standby-not pin and an enable pin) pick the mode. Three wake sources can pull the block out of sleep: a local wake pin, which reacts to either edge, and dominant-level comparators on the two bus wires. Two supply-good flags, one for the logic supply and one for the battery, force a safe low-power mode when a supply drops. The block drives the regulator-inhibit enable and the termination bias select. It also tells the pin multiplexers what to show on the error pin and the receive pin: the error flag, the received bus data, the wake interrupt or the battery power-on flag.

A change of the synchronised control pins selects a mode. A level that stays the same selects nothing, so a wake event can move the block out of sleep without the pins overriding it. The named states are NORMAL, STANDBY, PON_STANDBY, GOTO_SLEEP and SLEEP. The named transitions are:
- pin-select: a change of the control pins moves the block to the decoded mode.
- hold-expiry: GOTO_SLEEP moves to SLEEP when its timer runs out.
- wake-abort: a wake during GOTO_SLEEP moves the block to STANDBY.
- wake-exit: a wake during SLEEP moves the block to STANDBY.
- battery-loss: a low battery flag forces STANDBY from any state.
- supply-loss: a low logic supply reads as control pins 00 and so selects STANDBY.

Top module: `xcvr_pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is PON_STANDBY (code 2), INH is active, the power-on flag is 1, the wake flag is 0, the error-pin source is power-on flag (code 3), the receive-pin source is wake interrupt (code 2) and the termination select is 0.
- R2: Each control pin passes through two flops. A change of the synchronised pair {stb,en} selects a mode: 11 selects NORMAL (code 0), 10 selects PON_STANDBY (code 2), 01 selects GOTO_SLEEP (code 3) and 00 selects STANDBY (code 1).
- R3: GOTO_SLEEP keeps INH active for SLEEP_HOLD_CYC cycles and then enters SLEEP (code 4) with INH inactive. A pin change during that window selects the new mode instead.
- R4: A wake request during GOTO_SLEEP moves the block to STANDBY. INH stays active the whole time, and the block does not reach SLEEP afterwards while the pins are unchanged.
- R5: A local wake is a change of the synchronised wake pin, in either direction, whose new level lasts WAKE_DEB_CYC cycles. A shorter pulse has no effect.
- R6: A remote wake is canh_dom or canl_dom held high for BUS_DOM_CYC consecutive cycles. A shorter dominant period has no effect.
- R7: A wake in SLEEP moves the block to STANDBY with INH active. A wake in any low-power mode sets the wake flag. Wake inputs have no effect in NORMAL.
- R8: In NORMAL the error-pin source is error flag (code 0), the receive-pin source is bus data (code 1) and the termination select is 1. In PON_STANDBY they are power-on flag (3), wake interrupt (2) and 0. In STANDBY, GOTO_SLEEP and SLEEP they are wake interrupt (2), wake interrupt (2) and 0.
- R9: Entering NORMAL clears both the power-on flag and the wake flag.
- R10: While vcc_ok is 0 the control pins read as 00, which forces NORMAL to STANDBY. In SLEEP, pin changes are ignored while vcc_ok is 0.
- R11: While vbat_ok is 0 the mode is forced to STANDBY, INH is active and the power-on flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stb_pin | input | 1 | Standby-not control pin, asynchronous |
| en_pin | input | 1 | Enable control pin, asynchronous |
| wake_pin | input | 1 | Local wake pin, asynchronous |
| canh_dom | input | 1 | High bus wire wake comparator, 1 = dominant |
| canl_dom | input | 1 | Low bus wire wake comparator, 1 = dominant |
| vcc_ok | input | 1 | Logic supply above its threshold |
| vbat_ok | input | 1 | Battery supply above its flag level |
| mode | output | 3 | Current mode code |
| inh_en | output | 1 | 1 = INH driven active, 0 = high impedance |
| term_to_vcc | output | 1 | 1 = low-wire termination biased to VCC, 0 = to battery |
| err_src | output | 2 | Error-pin source select |
| rxd_src | output | 2 | Receive-pin source select |
| por_flag | output | 1 | Battery power-on flag |
| wake_flag | output | 1 | Latched wake interrupt |

## Verification
The bench targets the timing windows.

A wake glitch two cycles shorter than the debounce window must leave SLEEP alone; a debouncer that is off by a few cycles or sensitive to only one edge would wake or stay asleep at the wrong time. A bus wake arriving inside the go-to-sleep window must yield STANDBY that persists past the hold time; a design that lets the timer win, or re-reads the still-present 01 pins as a new command, would drop INH.

The bench also tests the supply corners. Pin changes made in SLEEP without VCC must be ignored. A battery drop must force STANDBY with the power-on flag set. Entering NORMAL must clear both flags, so a leaking flag shows up as a stale source on the error pin.

// File: rtl/xcvr_pwr_pkg.sv
package xcvr_pwr_pkg;

    typedef enum logic [2:0] {
        MD_NORMAL     = 3'd0,
        MD_STANDBY    = 3'd1,
        MD_PON_STBY   = 3'd2,
        MD_GOTO_SLEEP = 3'd3,
        MD_SLEEP      = 3'd4
    } pm_mode_t;

    typedef enum logic [1:0] {
        SRC_FAULT   = 2'd0,
        SRC_BUSDATA = 2'd1,
        SRC_WAKE    = 2'd2,
        SRC_PWRON   = 2'd3
    } pin_src_t;

    // {stb,en} pair to requested mode
    function automatic pm_mode_t decode_pins(input logic [1:0] pins);
        pm_mode_t m;
        case (pins)
            2'b11:   m = MD_NORMAL;
            2'b10:   m = MD_PON_STBY;
            2'b01:   m = MD_GOTO_SLEEP;
            default: m = MD_STANDBY;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
    parameter int WIDTH = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xcvr_wake_filter.sv
module xcvr_wake_filter #(
    parameter int WAKE_DEB_CYC = 8,
    parameter int BUS_DOM_CYC  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic wake_s,
    input  logic canh_dom,
    input  logic canl_dom,
    output logic wake_req
);
    localparam int DEB_W = $clog2(WAKE_DEB_CYC + 1);
    localparam int DOM_W = $clog2(BUS_DOM_CYC + 1);
    localparam logic [DEB_W-1:0] DEB_LAST = DEB_W'(WAKE_DEB_CYC - 1);
    localparam logic [DOM_W-1:0] DOM_LAST = DOM_W'(BUS_DOM_CYC - 1);
    localparam logic [DOM_W-1:0] DOM_SAT  = DOM_W'(BUS_DOM_CYC);

    // local wake: both edges, new level must persist
    logic             ref_q;
    logic [DEB_W-1:0] deb_cnt;
    logic             local_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q       <= 1'b0;
            deb_cnt     <= '0;
            local_pulse <= 1'b0;
        end else begin
            local_pulse <= 1'b0;
            if (!arm) begin
                ref_q   <= wake_s;
                deb_cnt <= '0;
            end else if (wake_s == ref_q) begin
                deb_cnt <= '0;
            end else if (deb_cnt == DEB_LAST) begin
                ref_q       <= wake_s;
                deb_cnt     <= '0;
                local_pulse <= 1'b1;
            end else begin
                deb_cnt <= deb_cnt + 1'b1;
            end
        end
    end

    // remote wake: one dominant-time filter per bus wire
    logic [1:0] dom_in;
    logic [1:0] dom_pulse;
    assign dom_in = {canl_dom, canh_dom};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [DOM_W-1:0] dom_cnt;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dom_cnt      <= '0;
                dom_pulse[g] <= 1'b0;
            end else begin
                dom_pulse[g] <= arm && dom_in[g] && (dom_cnt == DOM_LAST);
                if (!arm || !dom_in[g]) dom_cnt <= '0;
                else if (dom_cnt != DOM_SAT) dom_cnt <= dom_cnt + 1'b1;
            end
        end

        a_r6_line_was_dominant: assert property (@(posedge clk) disable iff (!rst_n)
            dom_pulse[g] |-> $past(dom_in[g]));
    end

    assign wake_req = local_pulse | (|dom_pulse);

    a_r5_local_moves_ref: assert property (@(posedge clk) disable iff (!rst_n)
        local_pulse |-> (ref_q != $past(ref_q)));
    a_r6_pulse_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dom_pulse[0] |=> !dom_pulse[0]);
endmodule

// File: rtl/xcvr_mode_fsm.sv
module xcvr_mode_fsm
    import xcvr_pwr_pkg::*;
#(
    parameter int SLEEP_HOLD_CYC = 20
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     stb_s,
    input  logic     en_s,
    input  logic     vcc_ok,
    input  logic     vbat_ok,
    input  logic     wake_req,
    output pm_mode_t state,
    output logic     inh_en,
    output logic     term_to_vcc,
    output pin_src_t err_src,
    output pin_src_t rxd_src,
    output logic     por_flag,
    output logic     wake_flag,
    output logic     wake_arm
);
    localparam int HOLD_W = $clog2(SLEEP_HOLD_CYC + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(SLEEP_HOLD_CYC - 1);

    pm_mode_t          nxt;
    logic [1:0]        eff_pins;
    logic [1:0]        pins_last;
    logic              pin_chg;
    logic [HOLD_W-1:0] hold_cnt;
    logic              enter_normal;

    // fail-safe: no logic supply reads as both pins low
    assign eff_pins     = vcc_ok ? {stb_s, en_s} : 2'b00;
    assign pin_chg      = (eff_pins != pins_last);
    assign enter_normal = (nxt == MD_NORMAL) && (state != MD_NORMAL);

    always_comb begin
        nxt = state;
        if (!vbat_ok)
            nxt = MD_STANDBY;
        else if (pin_chg && (vcc_ok || state != MD_SLEEP))
            nxt = decode_pins(eff_pins);
        else if (wake_req && (state == MD_SLEEP || state == MD_GOTO_SLEEP))
            nxt = MD_STANDBY;
        else if (state == MD_GOTO_SLEEP && hold_cnt == HOLD_LAST)
            nxt = MD_SLEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= MD_PON_STBY;
            pins_last <= 2'b00;
            hold_cnt  <= '0;
            por_flag  <= 1'b1;
            wake_flag <= 1'b0;
        end else begin
            state     <= nxt;
            pins_last <= eff_pins;
            if (state == MD_GOTO_SLEEP && nxt == MD_GOTO_SLEEP)
                hold_cnt <= hold_cnt + 1'b1;
            else
                hold_cnt <= '0;
            if (!vbat_ok)          por_flag <= 1'b1;
            else if (enter_normal) por_flag <= 1'b0;
            if (enter_normal)                          wake_flag <= 1'b0;
            else if (wake_req && state != MD_NORMAL)   wake_flag <= 1'b1;
        end
    end

    always_comb begin
        inh_en      = 1'b1;
        term_to_vcc = 1'b0;
        err_src     = SRC_WAKE;
        rxd_src     = SRC_WAKE;
        unique case (state)
            MD_NORMAL: begin
                term_to_vcc = 1'b1;
                err_src     = SRC_FAULT;
                rxd_src     = SRC_BUSDATA;
            end
            MD_PON_STBY:   err_src = SRC_PWRON;
            MD_SLEEP:      inh_en  = 1'b0;
            MD_STANDBY,
            MD_GOTO_SLEEP: inh_en  = 1'b1;
            default:       inh_en  = 1'b1;
        endcase
    end

    assign wake_arm = (state != MD_NORMAL);

    a_r3_sleep_after_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MD_SLEEP && $past(state) == MD_GOTO_SLEEP) |-> ($past(hold_cnt) == HOLD_LAST));
    a_r4_wake_beats_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MD_GOTO_SLEEP && wake_req && !pin_chg && vbat_ok) |=> (state == MD_STANDBY && inh_en));
    a_r9_flags_clear_in_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MD_NORMAL) |-> (!por_flag && !wake_flag));
    a_r10_sleep_ignores_pins_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MD_SLEEP && !vcc_ok && vbat_ok && !wake_req) |=> (state == MD_SLEEP));
    a_r11_battery_loss_standby: assert property (@(posedge clk) disable iff (!rst_n)
        !vbat_ok |=> (state == MD_STANDBY && por_flag));
endmodule

// File: rtl/xcvr_pwr_mode_ctrl.sv
module xcvr_pwr_mode_ctrl
    import xcvr_pwr_pkg::*;
#(
    parameter int WAKE_DEB_CYC   = 8,
    parameter int BUS_DOM_CYC    = 8,
    parameter int SLEEP_HOLD_CYC = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb_pin,
    input  logic       en_pin,
    input  logic       wake_pin,
    input  logic       canh_dom,
    input  logic       canl_dom,
    input  logic       vcc_ok,
    input  logic       vbat_ok,
    output logic [2:0] mode,
    output logic       inh_en,
    output logic       term_to_vcc,
    output logic [1:0] err_src,
    output logic [1:0] rxd_src,
    output logic       por_flag,
    output logic       wake_flag
);
    logic [2:0] pins_s;
    logic       wake_req;
    logic       wake_arm;
    pm_mode_t   state;
    pin_src_t   err_sel;
    pin_src_t   rxd_sel;

    xcvr_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({stb_pin, en_pin, wake_pin}),
        .q     (pins_s)
    );

    xcvr_wake_filter #(
        .WAKE_DEB_CYC (WAKE_DEB_CYC),
        .BUS_DOM_CYC  (BUS_DOM_CYC)
    ) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (wake_arm),
        .wake_s   (pins_s[0]),
        .canh_dom (canh_dom),
        .canl_dom (canl_dom),
        .wake_req (wake_req)
    );

    xcvr_mode_fsm #(.SLEEP_HOLD_CYC(SLEEP_HOLD_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb_s       (pins_s[2]),
        .en_s        (pins_s[1]),
        .vcc_ok      (vcc_ok),
        .vbat_ok     (vbat_ok),
        .wake_req    (wake_req),
        .state       (state),
        .inh_en      (inh_en),
        .term_to_vcc (term_to_vcc),
        .err_src     (err_sel),
        .rxd_src     (rxd_sel),
        .por_flag    (por_flag),
        .wake_flag   (wake_flag),
        .wake_arm    (wake_arm)
    );

    assign mode    = state;
    assign err_src = err_sel;
    assign rxd_src = rxd_sel;

    a_r7_sleep_means_inh_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4) |-> !inh_en);
    a_r8_normal_sources: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0) |-> (err_src == 2'd0 && rxd_src == 2'd1 && term_to_vcc));
endmodule

// File: tb/test_xcvr_pwr_mode_ctrl.sv
module test_xcvr_pwr_mode_ctrl;
    localparam int DEB  = 8;
    localparam int DOM  = 8;
    localparam int HOLD = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb_pin = 1'b0, en_pin = 1'b0, wake_pin = 1'b0;
    logic canh_dom = 1'b0, canl_dom = 1'b0;
    logic vcc_ok = 1'b1, vbat_ok = 1'b1;
    logic [2:0] mode;
    logic inh_en, term_to_vcc, por_flag, wake_flag;
    logic [1:0] err_src, rxd_src;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    xcvr_pwr_mode_ctrl #(.WAKE_DEB_CYC(DEB), .BUS_DOM_CYC(DOM), .SLEEP_HOLD_CYC(HOLD)) i_xcvr_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .stb_pin(stb_pin), .en_pin(en_pin), .wake_pin(wake_pin),
        .canh_dom(canh_dom), .canl_dom(canl_dom), .vcc_ok(vcc_ok), .vbat_ok(vbat_ok),
        .mode(mode), .inh_en(inh_en), .term_to_vcc(term_to_vcc), .err_src(err_src),
        .rxd_src(rxd_src), .por_flag(por_flag), .wake_flag(wake_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pins(input logic s, input logic e);
        stb_pin = s;
        en_pin  = e;
        step(4);
    endtask

    task automatic go_sleep();
        pins(1'b1, 1'b1);
        pins(1'b0, 1'b1);
        step(HOLD + 4);
    endtask

    task automatic t_reset();
        chk("R1", "mode", mode, 2);
        chk("R1", "inh", inh_en, 1);
        chk("R1", "por", por_flag, 1);
        chk("R1", "wake", wake_flag, 0);
        chk("R1", "err_src", err_src, 3);
        chk("R1", "rxd_src", rxd_src, 2);
        chk("R1", "term", term_to_vcc, 0);
    endtask

    task automatic t_pin_modes();
        pins(1'b1, 1'b1);
        chk("R2", "normal mode", mode, 0);
        chk("R9", "por cleared", por_flag, 0);
        chk("R8", "normal err_src", err_src, 0);
        chk("R8", "normal rxd_src", rxd_src, 1);
        chk("R8", "normal term", term_to_vcc, 1);
        pins(1'b1, 1'b0);
        chk("R2", "pon standby", mode, 2);
        chk("R8", "pon err_src", err_src, 3);
        chk("R8", "pon rxd_src", rxd_src, 2);
        pins(1'b0, 1'b0);
        chk("R2", "standby", mode, 1);
        chk("R8", "standby err_src", err_src, 2);
        chk("R8", "standby term", term_to_vcc, 0);
    endtask

    task automatic t_goto_sleep();
        pins(1'b0, 1'b1);
        chk("R2", "goto mode", mode, 3);
        step(HOLD / 2);
        chk("R3", "still goto", mode, 3);
        chk("R3", "inh held", inh_en, 1);
        step(HOLD);
        chk("R3", "sleep", mode, 4);
        chk("R3", "inh off", inh_en, 0);
        chk("R8", "sleep rxd_src", rxd_src, 2);
    endtask

    task automatic t_goto_redirect();
        pins(1'b1, 1'b1);
        pins(1'b0, 1'b1);
        pins(1'b0, 1'b0);
        chk("R3", "redirect standby", mode, 1);
        step(HOLD + 5);
        chk("R3", "no sleep after redirect", mode, 1);
    endtask

    task automatic t_local_wake();
        go_sleep();
        wake_pin = 1'b1;
        step(DEB - 2);
        wake_pin = 1'b0;
        step(DEB + 6);
        chk("R5", "short glitch stays asleep", mode, 4);
        chk("R5", "short glitch no flag", wake_flag, 0);
        wake_pin = 1'b1;
        step(DEB + 6);
        chk("R7", "rise wake standby", mode, 1);
        chk("R7", "rise wake inh", inh_en, 1);
        chk("R7", "rise wake flag", wake_flag, 1);
        pins(1'b1, 1'b1);
        chk("R9", "wake flag cleared", wake_flag, 0);
        go_sleep();
        wake_pin = 1'b0;
        step(DEB + 6);
        chk("R5", "fall wake standby", mode, 1);
    endtask

    task automatic t_remote_wake();
        go_sleep();
        canh_dom = 1'b1;
        step(DOM - 2);
        canh_dom = 1'b0;
        step(4);
        chk("R6", "short dominant stays asleep", mode, 4);
        canl_dom = 1'b1;
        step(DOM + 4);
        canl_dom = 1'b0;
        chk("R6", "canl wake standby", mode, 1);
        chk("R7", "canl wake flag", wake_flag, 1);
    endtask

    task automatic t_wake_in_goto();
        pins(1'b1, 1'b1);
        pins(1'b0, 1'b1);
        canh_dom = 1'b1;
        step(DOM + 4);
        canh_dom = 1'b0;
        chk("R4", "wake aborts goto", mode, 1);
        chk("R4", "inh kept", inh_en, 1);
        step(HOLD + 5);
        chk("R4", "stays standby", mode, 1);
        chk("R4", "inh still on", inh_en, 1);
    endtask

    task automatic t_wake_in_normal();
        pins(1'b1, 1'b1);
        canh_dom = 1'b1;
        wake_pin = 1'b1;
        step(DOM + 6);
        canh_dom = 1'b0;
        step(2);
        chk("R7", "normal ignores wake", mode, 0);
        chk("R7", "normal no flag", wake_flag, 0);
    endtask

    task automatic t_vcc_loss();
        vcc_ok = 1'b0;
        step(3);
        chk("R10", "vcc loss standby", mode, 1);
        vcc_ok = 1'b1;
        step(3);
        chk("R10", "vcc back normal", mode, 0);
        go_sleep();
        vcc_ok = 1'b0;
        step(2);
        pins(1'b1, 1'b1);
        step(4);
        chk("R10", "sleep ignores pins unpowered", mode, 4);
        vcc_ok = 1'b1;
        step(3);
        chk("R10", "powered pins accepted", mode, 0);
    endtask

    task automatic t_vbat_loss();
        vbat_ok = 1'b0;
        step(2);
        chk("R11", "vbat loss standby", mode, 1);
        chk("R11", "vbat loss inh", inh_en, 1);
        chk("R11", "vbat loss por", por_flag, 1);
        vbat_ok = 1'b1;
        step(2);
        pins(1'b1, 1'b0);
        chk("R11", "por readable", err_src, 3);
        chk("R11", "por still set", por_flag, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_pin_modes();
        t_goto_sleep();
        t_goto_redirect();
        t_local_wake();
        t_remote_wake();
        t_wake_in_goto();
        t_wake_in_normal();
        t_vcc_loss();
        t_vbat_loss();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule